// File: doc/BRIEF.md
# SEC-DED Error Correction for a Memory Data Path

This unit sits between a memory controller and its storage array. On the write side, it derives a block of check bits from the outgoing data word. The controller stores those check bits next to the data. On the read side, it takes the fetched data and check bits and recomputes the Hamming bits from the data alone. It then XORs the recomputed and fetched Hamming bits to form a syndrome, and folds in an overall parity bit. Each read is sorted into one of three classes: clean, corrected, or uncorrectable.

Each check bit is an even-parity sum over a group of codeword positions. The group is set by the binary weight of the position. One extra parity bit covers the whole stored word. A single flipped bit anywhere, in the data or in the check field, is repaired or reported as repaired. Any two flipped bits are flagged as uncorrectable.

The read result comes out one clock after the request. It carries a valid strobe and two status flags. The encoder output is purely combinational, so the check bits can be stored in the same cycle as the data.

Top module: `ecc_secded`

## Requirements
- R1: The Hamming bit count K is the smallest value with 2^K >= DATA_W+K+1. For DATA_W=8, K is 4. Codeword positions are numbered from 1. Hamming bit i occupies position 2^i. Data bit j fills the j-th position that is not a power of two, counting upward (3, 5, 6, 7, 9, ...). `wr_chk_o[i]` for i<K is the XOR of the data bits whose position has bit i set.
- R2: `wr_chk_o[K]` is the XOR of all data bits and all K Hamming bits. So the complete stored word has even parity.
- R3: `rd_valid_o` is high in exactly the cycle after each cycle in which `rd_valid_i` is high, and low otherwise.
- R4: A read whose word is as written returns the fetched data with `rd_corr_o` and `rd_fatal_o` both low.
- R5: A read with one flipped data bit returns the original data with `rd_corr_o` high and `rd_fatal_o` low.
- R6: A read with one flipped bit in the check field (a Hamming bit or the overall parity bit) returns the fetched data unchanged, with `rd_corr_o` high and `rd_fatal_o` low.
- R7: A read with two flipped bits anywhere in the stored word raises `rd_fatal_o` with `rd_corr_o` low. It returns the fetched data unaltered.
- R8: While `rd_valid_i` is low, `rd_data_o`, `rd_corr_o` and `rd_fatal_o` keep their values, whatever the read inputs carry.
- R9: During reset, `rd_valid_o`, `rd_corr_o`, `rd_fatal_o` and `rd_data_o` are all zero.
- R10: `rd_corr_o` and `rd_fatal_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data_i | input | DATA_W | Data word about to be stored |
| wr_chk_o | output | K+1 | Check field to store with it: Hamming bits [K-1:0], overall parity [K] |
| rd_valid_i | input | 1 | Fetched word present this cycle |
| rd_data_i | input | DATA_W | Fetched data bits |
| rd_chk_i | input | K+1 | Fetched check field |
| rd_valid_o | output | 1 | Result strobe, one cycle after `rd_valid_i` |
| rd_data_o | output | DATA_W | Corrected (or passed-through) data |
| rd_corr_o | output | 1 | A single-bit error was found and dealt with |
| rd_fatal_o | output | 1 | An error was found that cannot be corrected |

## Verification
Each fault has a quick, visible effect:
- A wrong position map or parity group shows at `wr_chk_o` for the affected data values, with no delay.
- On the read side, a wrong group flips the wrong data bit, or changes the class of a single error to fatal. This appears on `rd_data_o` and the flags one cycle after the offending read.
- A broken clock enable on the output register corrupts the held data during the first idle cycle that follows a read.

The sweep covers every data value at DATA_W=8. Each value is read clean, with each of the 13 possible single flips, and with each of the 78 possible double flips. A fault confined to one position or one data value is therefore still exposed.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  // Smallest Hamming bit count k with 2^k >= m + k + 1.
  function automatic int calc_ham_bits(input int m);
    int r;
    r = 0;
    for (int k = 1; k < 31; k++) begin
      if (r == 0 && (1 << k) >= m + k + 1) r = k;
    end
    return r;
  endfunction

  function automatic bit is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  typedef enum logic [1:0] {
    ECC_CLEAN = 2'd0,
    ECC_FIXED = 2'd1,
    ECC_FATAL = 2'd2
  } ecc_class_e;

endpackage

// File: rtl/ecc_hamming_gen.sv
module ecc_hamming_gen #(
  parameter int M = 8,
  parameter int K = 4
) (
  input  logic [M-1:0] data_i,
  output logic [K-1:0] ham_o,
  output logic         tot_par_o
);
  localparam int NPOS = M + K;

  // Walk the codeword positions. Positions that are not a power of two hold
  // data bits in ascending order; each feeds the groups its position selects.
  always_comb begin
    int d;
    ham_o = '0;
    d = 0;
    for (int p = 1; p <= NPOS; p++) begin
      if (!ecc_pkg::is_pow2(p)) begin
        for (int i = 0; i < K; i++) begin
          if (((p >> i) & 1) == 1) ham_o[i] = ham_o[i] ^ data_i[d];
        end
        d++;
      end
    end
  end

  assign tot_par_o = (^data_i) ^ (^ham_o);

endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome #(
  parameter int M = 8,
  parameter int K = 4
) (
  input  logic [M-1:0] data_i,
  input  logic [K:0]   chk_i,
  output logic [K-1:0] syn_o,
  output logic         par_odd_o
);
  logic [K-1:0] fresh;
  logic         fresh_tot;

  ecc_hamming_gen #(.M(M), .K(K)) u_regen (
    .data_i    (data_i),
    .ham_o     (fresh),
    .tot_par_o (fresh_tot)
  );

  assign syn_o = fresh ^ chk_i[K-1:0];
  // fresh_tot ^ ^syn leaves data parity XOR stored Hamming parity.
  assign par_odd_o = fresh_tot ^ (^syn_o) ^ chk_i[K];

endmodule

// File: rtl/ecc_fix.sv
module ecc_fix
  import ecc_pkg::*;
#(
  parameter int M = 8,
  parameter int K = 4
) (
  input  logic [M-1:0] raw_i,
  input  logic [K-1:0] syn_i,
  input  logic         par_odd_i,
  output logic [M-1:0] data_o,
  output ecc_class_e   cls_o
);
  localparam int NPOS = M + K;

  always_comb begin
    int d;
    int sv;
    data_o = raw_i;
    sv     = int'(syn_i);
    d      = 0;
    if (!par_odd_i) begin
      cls_o = (sv == 0) ? ECC_CLEAN : ECC_FATAL;
    end else if (is_pow2(sv)) begin
      cls_o = ECC_FIXED;              // check field bit only
    end else if (sv <= NPOS) begin
      cls_o = ECC_FIXED;
      for (int p = 1; p <= NPOS; p++) begin
        if (!is_pow2(p)) begin
          if (p == sv) data_o[d] = ~raw_i[d];
          d++;
        end
      end
    end else begin
      cls_o = ECC_FATAL;              // points outside the codeword
    end
  end

endmodule

// File: rtl/ecc_secded.sv
module ecc_secded
  import ecc_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int HAM_W  = calc_ham_bits(DATA_W),
  localparam int CHK_W  = HAM_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CHK_W-1:0]  wr_chk_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [CHK_W-1:0]  rd_chk_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_corr_o,
  output logic              rd_fatal_o
);

  // ---------------- write side ----------------
  logic [HAM_W-1:0] wr_ham;
  logic             wr_tot;

  ecc_hamming_gen #(.M(DATA_W), .K(HAM_W)) u_enc (
    .data_i    (wr_data_i),
    .ham_o     (wr_ham),
    .tot_par_o (wr_tot)
  );

  assign wr_chk_o = {wr_tot, wr_ham};

  // ---------------- read side ----------------
  logic [HAM_W-1:0]  syn;
  logic              par_odd;
  logic [DATA_W-1:0] fix_data;
  ecc_class_e        cls;

  ecc_syndrome #(.M(DATA_W), .K(HAM_W)) u_syn (
    .data_i    (rd_data_i),
    .chk_i     (rd_chk_i),
    .syn_o     (syn),
    .par_odd_o (par_odd)
  );

  ecc_fix #(.M(DATA_W), .K(HAM_W)) u_fix (
    .raw_i     (rd_data_i),
    .syn_i     (syn),
    .par_odd_i (par_odd),
    .data_o    (fix_data),
    .cls_o     (cls)
  );

  // ---------------- output register ----------------
  logic              valid_d, valid_q;
  logic [DATA_W-1:0] data_d, data_q;
  logic              corr_d, corr_q;
  logic              fatal_d, fatal_q;
  logic              res_en;

  assign res_en = rd_valid_i;

  always_comb begin
    valid_d = rd_valid_i;
    data_d  = data_q;
    corr_d  = corr_q;
    fatal_d = fatal_q;
    if (res_en) begin
      data_d  = fix_data;
      corr_d  = (cls == ECC_FIXED);
      fatal_d = (cls == ECC_FATAL);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      corr_q  <= 1'b0;
      fatal_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      corr_q  <= corr_d;
      fatal_q <= fatal_d;
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_data_o  = data_q;
  assign rd_corr_o  = corr_q;
  assign rd_fatal_o = fatal_q;

  // ---------------- assertions ----------------
  AST_WR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (^{wr_data_i, wr_chk_o}) == 1'b0); // R2

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_i |=> rd_valid_o); // R3

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_i |=> !rd_valid_o); // R3

  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_i && syn == '0 && !par_odd) |=>
      (rd_data_o == $past(rd_data_i) && !rd_corr_o && !rd_fatal_o)); // R4

  AST_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_i |=> ($countones(rd_data_o ^ $past(rd_data_i)) <= 1)); // R5

  AST_CHK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_i && par_odd && ((syn & (syn - 1'b1)) == '0)) |=>
      (rd_corr_o && rd_data_o == $past(rd_data_i))); // R6

  AST_DOUBLE_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_i && syn != '0 && !par_odd) |=>
      (rd_fatal_o && !rd_corr_o && rd_data_o == $past(rd_data_i))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_i |=> ($stable(rd_data_o) && $stable(rd_corr_o) && $stable(rd_fatal_o))); // R8

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_corr_o && rd_fatal_o)); // R10

endmodule

// File: tb/ecc_secded_tb.sv
`timescale 1ns/1ps
module ecc_secded_tb;
  localparam int DW = 8;
  localparam int HW = 4;
  localparam int CW = HW + 1;
  localparam int NP = DW + HW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] wr_data_i;
  logic [CW-1:0] wr_chk_o;
  logic          rd_valid_i;
  logic [DW-1:0] rd_data_i;
  logic [CW-1:0] rd_chk_i;
  logic          rd_valid_o;
  logic [DW-1:0] rd_data_o;
  logic          rd_corr_o;
  logic          rd_fatal_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ecc_secded #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_data_i(wr_data_i), .wr_chk_o(wr_chk_o),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .rd_chk_i(rd_chk_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .rd_corr_o(rd_corr_o), .rd_fatal_o(rd_fatal_o)
  );

  // Position of data bit j: the j-th non-power-of-two position from 1 up.
  function automatic int pos_of(input int j);
    int c = 0;
    for (int p = 1; p <= NP; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (c == j) return p;
        c++;
      end
    end
    return 0;
  endfunction

  function automatic logic [CW-1:0] expect_chk(input logic [DW-1:0] d);
    logic [CW-1:0] c = '0;
    for (int j = 0; j < DW; j++)
      for (int i = 0; i < HW; i++)
        if (((pos_of(j) >> i) & 1) == 1) c[i] = c[i] ^ d[j];
    c[HW] = (^d) ^ (^c[HW-1:0]);
    return c;
  endfunction

  // Bench codeword: index 0 = overall parity, 1..NP = Hamming positions.
  function automatic logic [NP:0] pack(input logic [DW-1:0] d, input logic [CW-1:0] c);
    logic [NP:0] w = '0;
    w[0] = c[HW];
    for (int i = 0; i < HW; i++) w[1 << i] = c[i];
    for (int j = 0; j < DW; j++) w[pos_of(j)] = d[j];
    return w;
  endfunction

  function automatic logic [DW-1:0] w_data(input logic [NP:0] w);
    logic [DW-1:0] d;
    for (int j = 0; j < DW; j++) d[j] = w[pos_of(j)];
    return d;
  endfunction

  function automatic logic [CW-1:0] w_chk(input logic [NP:0] w);
    logic [CW-1:0] c;
    c[HW] = w[0];
    for (int i = 0; i < HW; i++) c[i] = w[1 << i];
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; drives a read and checks the result one edge later.
  task automatic do_read(input logic [NP:0] w, input logic [DW-1:0] ed,
                         input logic ec, input logic ef, input string req);
    rd_valid_i = 1'b1;
    rd_data_i  = w_data(w);
    rd_chk_i   = w_chk(w);
    @(negedge clk);
    check({req, " valid (R3)"}, 32'(rd_valid_o), 32'd1);
    check({req, " data"},       32'(rd_data_o),  32'(ed));
    check({req, " corr"},       32'(rd_corr_o),  32'(ec));
    check({req, " fatal"},      32'(rd_fatal_o), 32'(ef));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NP:0]   w;
    logic [NP:0]   wf;
    logic [DW-1:0] hd;
    logic          hc;
    logic          hf;
    rst_n      = 1'b0;
    wr_data_i  = '0;
    rd_valid_i = 1'b0;
    rd_data_i  = 8'hA5;
    rd_chk_i   = '1;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 valid", 32'(rd_valid_o), 32'd0);
    check("R9 data",  32'(rd_data_o),  32'd0);
    check("R9 corr",  32'(rd_corr_o),  32'd0);
    check("R9 fatal", 32'(rd_fatal_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2 encoder, all data values
    for (int d = 0; d < 256; d++) begin
      wr_data_i = 8'(d);
      #0.1;
      check("R1 hamming bits", 32'(wr_chk_o[HW-1:0]), 32'(expect_chk(8'(d)) & 5'h0F));
      check("R2 overall parity", 32'(wr_chk_o[HW]), 32'(expect_chk(8'(d)) >> HW));
    end
    @(negedge clk);

    // Read sweep: clean, every single flip, every double flip
    for (int d = 0; d < 256; d++) begin
      w = pack(8'(d), expect_chk(8'(d)));
      do_read(w, 8'(d), 1'b0, 1'b0, "R4 clean");
      for (int b = 0; b <= NP; b++) begin
        wf = w;
        wf[b] = ~wf[b];
        if (b != 0 && (b & (b - 1)) != 0)
          do_read(wf, 8'(d), 1'b1, 1'b0, "R5 data flip");
        else
          do_read(wf, 8'(d), 1'b1, 1'b0, "R6 check flip");
      end
      for (int b = 0; b <= NP; b++) begin
        for (int b2 = b + 1; b2 <= NP; b2++) begin
          wf = w;
          wf[b]  = ~wf[b];
          wf[b2] = ~wf[b2];
          do_read(wf, w_data(wf), 1'b0, 1'b1, "R7 double flip");
        end
      end
      check("R10 flags exclusive", 32'(rd_corr_o & rd_fatal_o), 32'd0);
    end

    // R8 / R3: idle cycles with changing read inputs
    hd = rd_data_o;
    hc = rd_corr_o;
    hf = rd_fatal_o;
    for (int k = 0; k < 6; k++) begin
      rd_valid_i = 1'b0;
      rd_data_i  = 8'(k * 37 + 11);
      rd_chk_i   = 5'(k * 7 + 3);
      @(negedge clk);
      check("R3 valid idle", 32'(rd_valid_o), 32'd0);
      check("R8 data hold",  32'(rd_data_o),  32'(hd));
      check("R8 corr hold",  32'(rd_corr_o),  32'(hc));
      check("R8 fatal hold", 32'(rd_fatal_o), 32'(hf));
    end

    // A single-bit read after idle, then back to idle: valid pulses once
    w = pack(8'h3C, expect_chk(8'h3C));
    w[pos_of(5)] = ~w[pos_of(5)];
    do_read(w, 8'h3C, 1'b1, 1'b0, "R5 after idle");
    rd_valid_i = 1'b0;
    @(negedge clk);
    check("R3 single pulse", 32'(rd_valid_o), 32'd0);
    check("R8 hold after fix", 32'(rd_data_o), 32'h3C);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule